// File: doc/BRIEF.md
# SPI Target with Fault-First Readout

This block is the serial front end of a device register interface. An external host selects it by pulling an active-low chip-select and then clocks whole 32-bit words in and out with clock idle low. The host shifts command and data bits in on the input line. The block shifts a response word out on the output line. The first bit the host sees is the device-wide fault flag. It appears on the output line as soon as chip-select falls, before any serial clock edge, so the host learns the fault state from the first bit of every transfer.

All pins are sampled synchronously by the block clock, which must run well above the serial clock. Serial clock edges are found by comparing each sample with the one before. The response word comes from a parallel port. It is taken while the block is idle, and again at each 32-bit boundary inside one select window. Each time, its top bit is replaced by the live fault flag. Every completed input word is presented on a parallel output with a one-cycle strobe. A select window that closes in the middle of a word raises a sticky error flag.

Top module: `spi_fault_target`

## Requirements
- R1: While `cs_ni` is high, `sdo_en_o` is 0 and `sdo_o` is 0 (the line is released).
- R2: When `cs_ni` goes low, `sdo_en_o` rises and `sdo_o` shows the `fault_i` value sampled at the last clock edge before the fall, with no serial clock edge required.
- R3: The first rising serial clock edge of a word leaves `sdo_o` unchanged, so the fault bit is held through it.
- R4: Each detected falling serial clock edge moves `sdo_o` to the next lower bit of the response word. Bit 31 is the fault flag and bits 30..0 come from `resp_word_i`, sent MSB first.
- R5: On the 32nd falling edge of a word, while `cs_ni` stays low, the next word is loaded as `{fault_i, resp_word_i[30:0]}`, sampled at that edge.
- R6: `mosi_i` is sampled on rising serial clock edges, MSB first. On the 32nd rising edge of a word, `rx_word_o` takes the assembled word and `rx_valid_o` is high for exactly one clock cycle.
- R7: If `cs_ni` rises when the count of rising edges is not a multiple of 32, `frame_err_o` is set and stays set until `err_clr_i` is high at a clock edge. A set in the same cycle wins over a clear.
- R8: While `cs_ni` is high, bit counters and partial words are cleared, no word completes, and the next window starts at bit 31.
- R9: After reset, `rx_word_o` is 0, and `rx_valid_o` and `frame_err_o` are 0. `rx_word_o` holds its value until the next completed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; samples every serial pin |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip-select |
| sclk_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_en_o | output | 1 | Output enable for the pad driving sdo_o |
| fault_i | input | 1 | Device-wide fault flag |
| resp_word_i | input | 32 | Parallel response word; bit 31 is ignored |
| rx_word_o | output | 32 | Last completed input word |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_word_o |
| frame_err_o | output | 1 | Sticky frame-length error |
| err_clr_i | input | 1 | Clears frame_err_o |

## Verification
The bench looks at the output line right after chip-select falls, with no clock edge in between. A design that waits for a serial edge would show stale data there. It then checks that the fault bit survives the first rising edge; a design that shifts on rising edges would lose it at once. A 64-bit window changes the fault flag and the response word between the two words. A design that reloads only at select time, or that keeps the port's bit 31, would send the wrong second word. Aborted 20-bit windows, empty windows and a later full word show whether the error flag fires only on a partial word, whether it stays set until cleared, and whether leftover bits from the aborted window leak into the next captured word.

// File: rtl/spi_ft_pkg.sv
package spi_ft_pkg;
  localparam int unsigned WORD_W_DEF = 32;

  typedef struct packed {
    logic rise;     // sclk low->high while selected
    logic fall;     // sclk high->low while selected
    logic cs_rise;  // select window closes
  } spi_ev_t;
endpackage

// File: rtl/spi_ft_edge.sv
module spi_ft_edge
  import spi_ft_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cs_ni,
  input  logic    sclk_i,
  output spi_ev_t ev_o
);
  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  always_comb begin
    ev_o.rise    = ~cs_ni & sclk_i & ~sclk_q;
    ev_o.fall    = ~cs_ni & ~sclk_i & sclk_q;
    ev_o.cs_rise = cs_ni & ~cs_q;
  end
endmodule

// File: rtl/spi_ft_rx.sv
module spi_ft_rx
  import spi_ft_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  spi_ev_t           ev_i,
  input  logic              mosi_i,
  input  logic              err_clr_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              frame_err_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[WORD_W-2:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sh_q       <= '0;
      rx_word_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (cs_ni) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (ev_i.rise) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          rx_word_o  <= sh_nxt;
          rx_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // cnt_q still holds the window's count on the cs_rise cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            frame_err_o <= 1'b0;
    else if (ev_i.cs_rise && cnt_q != '0)   frame_err_o <= 1'b1;
    else if (err_clr_i)                     frame_err_o <= 1'b0;
  end
endmodule

// File: rtl/spi_ft_tx.sv
module spi_ft_tx
  import spi_ft_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  spi_ev_t           ev_i,
  input  logic              fault_i,
  input  logic [WORD_W-1:0] resp_word_i,
  output logic              tx_bit_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] fresh;

  assign fresh = {fault_i, resp_word_i[WORD_W-2:0]};

  // idle: keep a fresh word staged so bit 31 is valid the moment cs falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_ni) begin
      cnt_q <= '0;
      sh_q  <= fresh;
    end else if (ev_i.fall) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        sh_q  <= fresh;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign tx_bit_o = sh_q[WORD_W-1];
endmodule

// File: rtl/spi_fault_target.sv
module spi_fault_target
  import spi_ft_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  input  logic              fault_i,
  input  logic [WORD_W-1:0] resp_word_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o,
  output logic              frame_err_o,
  input  logic              err_clr_i
);
  spi_ev_t ev;
  logic    tx_bit;

  spi_ft_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_ni (cs_ni),
    .sclk_i(sclk_i),
    .ev_o  (ev)
  );

  spi_ft_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .ev_i       (ev),
    .mosi_i     (mosi_i),
    .err_clr_i  (err_clr_i),
    .rx_word_o  (rx_word_o),
    .rx_valid_o (rx_valid_o),
    .frame_err_o(frame_err_o)
  );

  spi_ft_tx #(.WORD_W(WORD_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .ev_i       (ev),
    .fault_i    (fault_i),
    .resp_word_i(resp_word_i),
    .tx_bit_o   (tx_bit)
  );

  // enable follows cs directly: no clock edge between select and first bit
  assign sdo_en_o = ~cs_ni;
  assign sdo_o    = ~cs_ni & tx_bit;
endmodule

// File: rtl/spi_fault_target_chk.sv
module spi_fault_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sclk_i,
  input logic sdo_o,
  input logic rx_valid_o,
  input logic frame_err_o,
  input logic err_clr_i
);
  // output moves only after a clock edge that saw sclk high then low
  assert_sdo_moves_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !$past(cs_ni) && !$past(cs_ni, 2) && sdo_o != $past(sdo_o))
      |-> (!$past(sclk_i) && $past(sclk_i, 2)));

  assert_valid_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_no_word_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> !rx_valid_o);

  assert_ferr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o && !err_clr_i) |=> frame_err_o);

  assert_ferr_on_close_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> ($past(cs_ni) && !$past(cs_ni, 2)));
endmodule

bind spi_fault_target spi_fault_target_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .sclk_i     (sclk_i),
  .sdo_o      (sdo_o),
  .rx_valid_o (rx_valid_o),
  .frame_err_o(frame_err_o),
  .err_clr_i  (err_clr_i)
);

// File: tb/tb_spi_fault_target.sv
module tb_spi_fault_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic        fault = 1'b0;
  logic [31:0] resp = '0;
  logic        clr = 1'b0;
  logic        sdo, sdo_en, rx_valid, ferr;
  logic [31:0] rx_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_fault_target dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .fault_i(fault), .resp_word_i(resp),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid), .frame_err_o(ferr), .err_clr_i(clr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_word, m_rx;
  int          m_fall;
  bit          m_valid, m_ferr, m_sclk_prev, m_cs_prev;
  bit          rxq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = '0; m_rx = '0; m_fall = 0; m_valid = 0; m_ferr = 0;
      m_sclk_prev = 0; m_cs_prev = 1; rxq.delete();
    end else begin
      m_valid = 0;
      if (cs_n && !m_cs_prev && rxq.size() != 0) m_ferr = 1;
      else if (clr) m_ferr = 0;
      if (cs_n) begin
        rxq.delete();
        m_fall = 0;
        m_word = {fault, resp[30:0]};
      end else begin
        if (sclk && !m_sclk_prev) begin
          rxq.push_back(mosi);
          if (rxq.size() == 32) begin
            for (int i = 0; i < 32; i++) m_rx[31-i] = rxq[i];
            m_valid = 1;
            rxq.delete();
          end
        end
        if (!sclk && m_sclk_prev) begin
          if (m_fall == 31) begin
            m_fall = 0;
            m_word = {fault, resp[30:0]};
          end else m_fall++;
        end
      end
      m_sclk_prev = sclk;
      m_cs_prev = cs_n;
    end
  end

  // per-clock comparison after all updates settle
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      chk("R1 sdo_en", sdo_en, !cs_n);
      chk("R4 sdo", sdo, cs_n ? 1'b0 : m_word[31-m_fall]);
      chk("R6 rx_word", rx_word, m_rx);
      chk("R6 rx_valid", rx_valid, m_valid);
      chk("R7 frame_err", ferr, m_ferr);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one select window of nbits; response/fault switch after bit 16
  task automatic xfer(input int nbits, input logic [63:0] din,
                      input logic [31:0] r1, input logic f1,
                      input logic [31:0] r2, input logic f2,
                      output logic [63:0] dout);
    @(negedge clk);
    resp = r1; fault = f1;
    wait_n(2);
    cs_n = 1'b0;
    #1;
    chk("R2 enable at select", sdo_en, 1'b1);
    chk("R2 fault bit at select", sdo, f1);
    dout = '0;
    for (int b = 0; b < nbits; b++) begin
      if (b == 16) begin resp = r2; fault = f2; end
      mosi = din[nbits-1-b];
      wait_n(2);
      dout[nbits-1-b] = sdo;
      sclk = 1'b1;
      wait_n(2);
      if (b == 0) begin
        #1;
        chk("R3 fault held over first rise", sdo, f1);
      end
      sclk = 1'b0;
    end
    wait_n(2);
    cs_n = 1'b1;
    wait_n(3);
  endtask

  initial begin
    logic [63:0] got;
    wait_n(3);
    #1;
    chk("R9 rx_word reset", rx_word, 32'h0);
    chk("R9 rx_valid reset", rx_valid, 1'b0);
    chk("R9 frame_err reset", ferr, 1'b0);
    chk("R1 sdo_en reset", sdo_en, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_n(2);

    xfer(32, 64'h0000_0000_A5C3_0F96, 32'hFFFF_0001, 1'b0, 32'hFFFF_0001, 1'b0, got);
    chk("R4 word out fault=0", got[31:0], {1'b0, 31'h7FFF_0001});
    chk("R6 captured word", rx_word, 32'hA5C3_0F96);

    xfer(32, 64'h0000_0000_1234_5678, 32'h0F0F_F0F0, 1'b1, 32'h0F0F_F0F0, 1'b1, got);
    chk("R4 word out fault=1, port bit31 ignored", got[31:0], {1'b1, 31'h0F0F_F0F0});
    chk("R6 captured word 2", rx_word, 32'h1234_5678);

    xfer(64, 64'hDEAD_BEEF_0BAD_F00D, 32'h8000_00FF, 1'b0, 32'h0123_4567, 1'b1, got);
    chk("R4 first word", got[63:32], {1'b0, 31'h0000_00FF});
    chk("R5 reload at boundary", got[31:0], {1'b1, 31'h0123_4567});
    chk("R6 last of two words", rx_word, 32'h0BAD_F00D);

    xfer(20, 64'h0000_0000_000F_FFFF, 32'h0, 1'b0, 32'h0, 1'b0, got);
    chk("R7 partial window flags", ferr, 1'b1);
    chk("R9 rx_word held after abort", rx_word, 32'h0BAD_F00D);
    wait_n(4);
    chk("R7 flag sticky", ferr, 1'b1);

    xfer(0, 64'h0, 32'h0, 1'b1, 32'h0, 1'b1, got);
    chk("R7 empty window keeps flag", ferr, 1'b1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    #1;
    chk("R7 cleared", ferr, 1'b0);

    xfer(32, 64'h0000_0000_C001_D00D, 32'h5555_AAAA, 1'b0, 32'h5555_AAAA, 1'b0, got);
    chk("R8 fresh start after abort", rx_word, 32'hC001_D00D);
    chk("R8 tx restarts at bit31", got[31:0], {1'b0, 31'h5555_AAAA});
    chk("R7 full word no flag", ferr, 1'b0);

    xfer(0, 64'h0, 32'h0, 1'b0, 32'h0, 1'b0, got);
    chk("R7 empty window no flag", ferr, 1'b0);

    wait_n(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule